// File: doc/BRIEF.md
# Configurable SPI Shift Interface

This block moves one byte at a time over a four-wire serial link. A small processor-side port reaches two 8-bit registers: a control register that fixes the clock idle level, the sampling edge, the bit order, the use of the select pin and two sticky flags, and a data register. The data register holds the byte to send before a transfer and the byte received after it.

As master, a write to the data register while the engine is idle starts a transfer. The block then produces sixteen serial clock edges at a fixed division of the system clock, drives the select pin low for the duration, and raises a completion flag. As slave, the external serial clock, data and select inputs pass through synchronising flip-flops. Edges are detected in the system clock domain, and the engine shifts while it is selected. A data write that arrives mid-transfer is discarded and raises a collision flag. A parameter can remove the collision flag.

Register map: address 0 is the control register and address 1 is the data register. Control bits: [7:6] spare storage, [5] clock idle-low select, [4] edge select, [3] MSB-first select, [2] select-pin enable, [1] collision flag, [0] transfer-done flag.

Top module: `spi_shift_unit`

## Requirements
- R1: After reset both registers read 0x00, `sck_o` is high, and `scs_n_oe` is low.
- R2: Control bit 5 sets the clock idle level. 0 makes SCK idle high and 1 makes it idle low. The master's `sck_o` returns to that level after every transfer.
- R3: Data is sampled on the rising SCK edge when bits 5 and 4 are equal and on the falling edge when they differ. SDO changes only on edges of the other direction.
- R4: Control bit 3 at 1 sends and receives the most significant bit first. At 0, the least significant bit goes first. After a transfer the data register holds the received byte in its natural bit positions.
- R5: In master mode (`is_master`=1), a data write while idle starts a transfer of exactly 16 SCK edges spaced CLK_DIV system clocks apart. At its end, control bit 0 reads 1.
- R6: Bits 7:6 are plain read/write storage. Bits 1 and 0 are cleared only by writing 0 to them. Writing 1 to them leaves them unchanged.
- R7: A data write while a transfer is in progress leaves the shift register untouched and sets control bit 1.
- R8: With COLL_EN=0, control bit 1 always reads 0, and a data write during a transfer is still discarded.
- R9: In master mode with control bit 2 at 1, `scs_n_oe` is 1 and `scs_n_o` is low during the transfer and high otherwise. With bit 2 at 0, `scs_n_oe` is 0.
- R10: In slave mode, edges on `sck_i` are counted while `scs_n_i` is low, or at any time when control bit 2 is 0. After 16 edges the data register holds the byte received on `sdi` and bit 0 reads 1.
- R11: In slave mode with control bit 2 at 1, edges while `scs_n_i` is high are ignored. Raising `scs_n_i` discards a partly counted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 selects master operation, 0 selects slave |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| scs_n_i | input | 1 | Active-low select input (slave) |
| scs_n_o | output | 1 | Active-low select output (master) |
| scs_n_oe | output | 1 | Select output enable |

## Verification
Two situations are hard to reach from the ports. The first is a data write that lands inside a running master transfer. The bench reaches it by issuing a second write partway through the edge-watching loop. It then checks the collision flag, the received byte on both the default and the COLL_EN=0 instance, and the way the flag behaves when 1 or 0 is written to it. The second is a slave transfer that is cut off partway through. The bench first clocks sixteen edges while the slave is deselected. It then clocks six edges while selected and raises the select. A full transfer follows, and it must deliver an exact byte and a single completion.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int DATA_W = 8;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef struct packed {
    logic [1:0] spare;
    logic       idle_low;
    logic       edge_sel;
    logic       msb_first;
    logic       sel_en;
    logic       coll;
    logic       done;
  } spi_ctrl_t;

endpackage

// File: rtl/spi_regs.sv
module spi_regs
  import spi_shift_pkg::*;
#(
  parameter bit COLL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              last_edge,
  input  logic [DATA_W-1:0] shreg,
  output spi_ctrl_t         ctrl,
  output logic [DATA_W-1:0] rdata
);

  spi_ctrl_t ctrl_q, ctrl_d;
  logic      ctrl_we, data_we;

  assign ctrl_we = we && (addr == ADDR_CTRL);
  assign data_we = we && (addr == ADDR_DATA);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.spare     = wdata[7:6];
      ctrl_d.idle_low  = wdata[5];
      ctrl_d.edge_sel  = wdata[4];
      ctrl_d.msb_first = wdata[3];
      ctrl_d.sel_en    = wdata[2];
      ctrl_d.coll      = ctrl_q.coll & wdata[1];
      ctrl_d.done      = ctrl_q.done & wdata[0];
    end
    if (last_edge) begin
      ctrl_d.done = 1'b1;
    end
    if (COLL_EN && data_we && busy) begin
      ctrl_d.coll = 1'b1;
    end
    if (!COLL_EN) begin
      ctrl_d.coll = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign rdata = (addr == ADDR_DATA) ? shreg : ctrl_q;

  // R7
  coll_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.coll) |-> $past(data_we && busy));

  // R5
  done_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.done) |-> $past(last_edge));

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int CLK_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic start,
  input  logic last_edge,
  input  logic idle_lvl,
  input  logic sel_en,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic scs_n_i,
  output logic sck_lvl,
  output logic edge_pulse,
  output logic edge_rise,
  output logic sdi_smp,
  output logic running,
  output logic deselect
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);

  // master clock generation
  logic [CW-1:0] div_q, div_d;
  logic          lvl_q, lvl_d;
  logic          run_q, run_d;
  logic          tick;

  assign tick = run_q && (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    lvl_d = lvl_q;
    run_d = run_q;
    if (!run_q) begin
      lvl_d = idle_lvl;
      div_d = '0;
      if (start) begin
        run_d = 1'b1;
      end
    end else if (tick) begin
      div_d = '0;
      lvl_d = ~lvl_q;
      if (last_edge) begin
        run_d = 1'b0;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lvl_q <= 1'b1;
      run_q <= 1'b0;
    end else begin
      div_q <= div_d;
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  // slave input synchronisers; clock and select reset to their idle
  // values so that reset release creates no false edge
  logic [SYNC_STAGES-1:0] sck_pipe, sdi_pipe, scs_pipe;
  logic                   sck_prev;
  logic                   sck_s, sdi_s, scs_s, slave_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '1;
      scs_pipe <= '1;
      sdi_pipe <= '0;
      sck_prev <= 1'b1;
    end else begin
      sck_pipe <= {sck_pipe[SYNC_STAGES-2:0], sck_i};
      scs_pipe <= {scs_pipe[SYNC_STAGES-2:0], scs_n_i};
      sdi_pipe <= {sdi_pipe[SYNC_STAGES-2:0], sdi_i};
      sck_prev <= sck_pipe[SYNC_STAGES-1];
    end
  end

  assign sck_s      = sck_pipe[SYNC_STAGES-1];
  assign sdi_s      = sdi_pipe[SYNC_STAGES-1];
  assign scs_s      = scs_pipe[SYNC_STAGES-1];
  assign slave_edge = (sck_s ^ sck_prev) && (!sel_en || !scs_s);

  assign edge_pulse = is_master ? tick    : slave_edge;
  assign edge_rise  = is_master ? ~lvl_q  : sck_s;
  assign sdi_smp    = is_master ? sdi_i   : sdi_s;
  assign deselect   = !is_master && sel_en && scs_s;
  assign sck_lvl    = lvl_q;
  assign running    = run_q;

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && $past(!run_q) && $stable(idle_lvl)) |-> (lvl_q == idle_lvl));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] wdata,
  input  logic         edge_pulse,
  input  logic         edge_rise,
  input  logic         cap_rise,
  input  logic         msb_first,
  input  logic         sdi_smp,
  input  logic         deselect,
  output logic [W-1:0] shreg,
  output logic         sdo,
  output logic         busy,
  output logic         last_edge
);

  localparam int EDGES = 2 * W;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EDGES - 1);

  logic [W-1:0]     sh_q, sh_d;
  logic             sdo_q, sdo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             capture, drive;

  assign capture   = edge_pulse && (edge_rise == cap_rise);
  assign drive     = edge_pulse && !capture;
  assign last_edge = edge_pulse && !deselect && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (deselect) begin
      cnt_d = '0;
    end else if (edge_pulse) begin
      cnt_d = last_edge ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    sh_d  = sh_q;
    sdo_d = sdo_q;
    if (load) begin
      sh_d  = wdata;
      sdo_d = msb_first ? wdata[W-1] : wdata[0];
    end else begin
      if (capture) begin
        sh_d = msb_first ? {sh_q[W-2:0], sdi_smp} : {sdi_smp, sh_q[W-1:1]};
      end
      if (drive) begin
        sdo_d = msb_first ? sh_q[W-1] : sh_q[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      sdo_q <= sdo_d;
      cnt_q <= cnt_d;
    end
  end

  assign shreg = sh_q;
  assign sdo   = sdo_q;
  assign busy  = (cnt_q != '0);

  // R3
  sdo_hold_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !load) |=> $stable(sdo_q));

  // R11
  deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deselect |=> !busy);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_shift_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter bit COLL_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  input  logic              scs_n_i,
  output logic              scs_n_o,
  output logic              scs_n_oe
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  spi_ctrl_t         ctrl;
  logic [DATA_W-1:0] shreg;
  logic              sh_busy, running, busy, last_edge;
  logic              data_we, load, start;
  logic              edge_pulse, edge_rise, sdi_smp, deselect, sck_lvl;

  assign busy    = sh_busy | running;
  assign data_we = reg_we && (reg_addr == ADDR_DATA);
  assign load    = data_we && !busy;
  assign start   = load && is_master;

  spi_regs #(.COLL_EN(COLL_EN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .busy      (busy),
    .last_edge (last_edge),
    .shreg     (shreg),
    .ctrl      (ctrl),
    .rdata     (reg_rdata)
  );

  spi_clkgen #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .is_master  (is_master),
    .start      (start),
    .last_edge  (last_edge),
    .idle_lvl   (~ctrl.idle_low),
    .sel_en     (ctrl.sel_en),
    .sck_i      (sck_i),
    .sdi_i      (sdi),
    .scs_n_i    (scs_n_i),
    .sck_lvl    (sck_lvl),
    .edge_pulse (edge_pulse),
    .edge_rise  (edge_rise),
    .sdi_smp    (sdi_smp),
    .running    (running),
    .deselect   (deselect)
  );

  spi_shifter #(.W(DATA_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load       (load),
    .wdata      (reg_wdata),
    .edge_pulse (edge_pulse),
    .edge_rise  (edge_rise),
    .cap_rise   (ctrl.idle_low == ctrl.edge_sel),
    .msb_first  (ctrl.msb_first),
    .sdi_smp    (sdi_smp),
    .deselect   (deselect),
    .shreg      (shreg),
    .sdo        (sdo),
    .busy       (sh_busy),
    .last_edge  (last_edge)
  );

  assign sck_o    = sck_lvl;
  assign sck_oe   = is_master;
  assign scs_n_o  = ~running;
  assign scs_n_oe = is_master & ctrl.sel_en;

endmodule

// File: tb/spi_shift_unit_tb.sv
module spi_shift_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {master, ctrl, byte sent by the block, byte sent by the bench}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'h0C, 8'hA5, 8'h3C},
    {1'b1, 8'h14, 8'h81, 8'h7E},
    {1'b1, 8'h28, 8'h0F, 8'hF0},
    {1'b1, 8'h30, 8'h96, 8'h69},
    {1'b1, 8'hC4, 8'h01, 8'h80},
    {1'b0, 8'h0C, 8'h5A, 8'hC3},
    {1'b0, 8'h24, 8'h33, 8'hE1},
    {1'b0, 8'h38, 8'h7F, 8'h02},
    {1'b0, 8'h14, 8'hC8, 8'h1D}
  };

  logic       clk, rst_n, mst, we, addr;
  logic [7:0] wdata, rdata, rdata_nc;
  logic       sck_in, sdi_b, scs_in;
  logic       sck_o, sck_oe, sdo, scs_n_o, scs_n_oe;
  logic       sck_o_nc, sck_oe_nc, sdo_nc, scs_n_o_nc, scs_n_oe_nc;
  int         n_checks, n_fail;

  spi_shift_unit #(.CLK_DIV(2), .COLL_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(mst), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .sck_i(sck_in), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdi(sdi_b), .sdo(sdo), .scs_n_i(scs_in),
    .scs_n_o(scs_n_o), .scs_n_oe(scs_n_oe)
  );

  spi_shift_unit #(.CLK_DIV(2), .COLL_EN(1'b0)) u_dut_nocoll (
    .clk(clk), .rst_n(rst_n), .is_master(mst), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_nc), .sck_i(sck_in), .sck_o(sck_o_nc),
    .sck_oe(sck_oe_nc), .sdi(sdi_b), .sdo(sdo_nc), .scs_n_i(scs_in),
    .scs_n_o(scs_n_o_nc), .scs_n_oe(scs_n_oe_nc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic bitof(input logic [7:0] b, input int k, input logic msb);
    if (k > 7) return 1'b0;
    return msb ? b[7-k] : b[k];
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d, output logic [7:0] dnc);
    addr = a;
    #1;
    d = rdata;
    dnc = rdata_nc;
  endtask

  // master transfer with the bench acting as the far device
  task automatic master_xfer(input logic [7:0] ctrl, input logic [7:0] tx,
                             input logic [7:0] rxb, input int coll_at,
                             output logic [7:0] got);
    logic cr, msb, prev, first, fin;
    int   caps;
    cr = (ctrl[5] == ctrl[4]);
    msb = ctrl[3];
    sdi_b = bitof(rxb, 0, msb);
    wr(1'b1, tx);
    addr = 1'b0;
    prev = sck_o; first = 1'b1; fin = 1'b0; caps = 0; got = '0;
    for (int i = 0; i < 2000 && !fin; i++) begin
      @(negedge clk);
      if (sck_o != prev) begin
        if (first) begin
          // R9 select pin during the transfer
          chk("R9 scs_n_oe", {7'd0, scs_n_oe}, {7'd0, ctrl[2]});
          if (ctrl[2]) chk("R9 scs_n_o active", {7'd0, scs_n_o}, 8'd0);
          first = 1'b0;
        end
        if (sck_o == cr) begin
          if (caps < 8) begin
            if (msb) got[7-caps] = sdo; else got[caps] = sdo;
          end
          caps++;
        end else begin
          sdi_b = bitof(rxb, caps, msb);
        end
        prev = sck_o;
      end
      if (addr == 1'b0 && rdata[0]) fin = 1'b1;
      if (coll_at > 0 && i == coll_at) begin
        addr = 1'b1; wdata = 8'h3C; we = 1'b1;
      end else if (coll_at > 0 && i == coll_at + 1) begin
        we = 1'b0; addr = 1'b0;
      end
    end
    if (!fin) chk("R5 completion", 8'd0, 8'd1);
  endtask

  // slave transfer with the bench acting as master
  task automatic slave_run(input logic [7:0] ctrl, input logic [7:0] sbyte,
                           input int n, input logic sel_low, output logic [7:0] got);
    logic cr, msb, lvl, nl;
    int   caps;
    cr = (ctrl[5] == ctrl[4]);
    msb = ctrl[3];
    lvl = ~ctrl[5];
    caps = 0; got = '0;
    sdi_b = bitof(sbyte, 0, msb);
    if (sel_low) scs_in = 1'b0;
    repeat (8) @(negedge clk);
    for (int e = 0; e < n; e++) begin
      nl = ~lvl;
      if (nl == cr) begin
        if (caps < 8) begin
          if (msb) got[7-caps] = sdo; else got[caps] = sdo;
        end
        caps++;
        sck_in = nl;
      end else begin
        sck_in = nl;
        sdi_b = bitof(sbyte, caps, msb);
      end
      lvl = nl;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got, r, rnc;
    logic [24:0] v;
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; mst = 1'b1; we = 1'b0; addr = 1'b0; wdata = '0;
    sck_in = 1'b1; sdi_b = 1'b0; scs_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, r, rnc); chk("R1 ctrl reset", r, 8'h00);
    rd(1'b1, r, rnc); chk("R1 data reset", r, 8'h00);
    chk("R1 sck idle", {7'd0, sck_o}, 8'd1);
    chk("R1 scs_n_oe", {7'd0, scs_n_oe}, 8'd0);

    // table walk: R2 R3 R4 R5 R9 R10
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      if (v[24]) begin
        mst = 1'b1;
        wr(1'b0, v[23:16]);
        repeat (4) @(negedge clk);
        chk("R2 idle level before", {7'd0, sck_o}, {7'd0, ~v[21]});
        master_xfer(v[23:16], v[15:8], v[7:0], 0, got);
        repeat (2) @(negedge clk);
        chk("R2 idle level after", {7'd0, sck_o}, {7'd0, ~v[21]});
        if (v[18]) chk("R9 scs_n_o released", {7'd0, scs_n_o}, 8'd1);
      end else begin
        mst = 1'b0;
        scs_in = 1'b1;
        wr(1'b0, v[23:16]);
        sck_in = ~v[21];
        repeat (6) @(negedge clk);
        wr(1'b1, v[15:8]);
        slave_run(v[23:16], v[7:0], 16, v[18], got);
        scs_in = 1'b1;
        repeat (6) @(negedge clk);
      end
      chk("R3 R4 byte shifted out", got, v[15:8]);
      rd(1'b1, r, rnc); chk("R4 R10 byte received", r, v[7:0]);
      rd(1'b0, r, rnc); chk("R5 R6 ctrl with done", r, v[23:16] | 8'h01);
    end

    // R7 R8 collision in master mode
    mst = 1'b1;
    wr(1'b0, 8'h0C);
    repeat (4) @(negedge clk);
    master_xfer(8'h0C, 8'hA5, 8'h99, 6, got);
    repeat (2) @(negedge clk);
    chk("R7 shifted out despite write", got, 8'hA5);
    rd(1'b1, r, rnc);
    chk("R7 data after collision", r, 8'h99);
    chk("R8 data after dropped write", rnc, 8'h99);
    rd(1'b0, r, rnc);
    chk("R7 collision flag", r, 8'h0F);
    chk("R8 no collision flag", rnc, 8'h0D);

    // R6 writing 1 keeps flags, writing 0 clears, spare bits store
    wr(1'b0, 8'h0F);
    rd(1'b0, r, rnc); chk("R6 write one keeps flags", r, 8'h0F);
    wr(1'b0, 8'h0C);
    rd(1'b0, r, rnc); chk("R6 write zero clears flags", r, 8'h0C);
    wr(1'b0, 8'hC0);
    rd(1'b0, r, rnc); chk("R6 spare bits", r, 8'hC0);
    chk("R9 select output disabled", {7'd0, scs_n_oe}, 8'd0);

    // R11 slave deselect handling
    mst = 1'b0;
    scs_in = 1'b1;
    wr(1'b0, 8'h0C);
    sck_in = 1'b1;
    repeat (6) @(negedge clk);
    wr(1'b1, 8'h11);
    slave_run(8'h0C, 8'hFF, 16, 1'b0, got);
    rd(1'b0, r, rnc); chk("R11 no done while deselected", r, 8'h0C);
    rd(1'b1, r, rnc); chk("R11 data untouched while deselected", r, 8'h11);
    slave_run(8'h0C, 8'hFF, 6, 1'b1, got);
    scs_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(1'b0, r, rnc); chk("R11 no done after partial", r, 8'h0C);
    slave_run(8'h0C, 8'h4B, 16, 1'b1, got);
    scs_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(1'b1, r, rnc); chk("R11 R10 byte after restart", r, 8'h4B);
    rd(1'b0, r, rnc); chk("R11 done after restart", r, 8'h0D);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule